// File: doc/BRIEF.md
# Interrupt Status Set/Clear Unit

This block keeps a 32-bit interrupt status word for a memory-mapped device and turns changes to that word into an interrupt. Bits are set by OR-ing a mask into the word and cleared by AND-ing with the inverse of a mask. Masks reach the word from two places. Software writes a set mask through its raise port and a clear mask through its acknowledge port. Two internal event inputs set fixed bits: one for compute-done and one for transfer-done.

The interrupt is signalled in one of two ways, chosen by a mode input. In level mode a registered line is asserted and held until an acknowledge empties the word. In message mode every raise that leaves the word nonzero produces a single-cycle notification pulse, and an acknowledge never pulls the line low. The status word is always visible on a read port. Reading it changes nothing in the block.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status word, the level line and the message pulse are all zero.
- R2: A software raise ORs its mask into the status word, and the result is visible on `status_o` after the next clock edge.
- R3: An acknowledge clears exactly the bits that are set in its mask. All other bits keep their value.
- R4: A compute-done event sets bit 0 (0x00000001). A transfer-done event sets bit 8 (0x00000100).
- R5: When a raise and an acknowledge arrive in the same cycle, the clear is applied first and the set second. A bit named by both ends up set.
- R6: In level mode, a raise event that leaves the word nonzero drives `irq_level_o` high from the next cycle.
- R7: In level mode, `irq_level_o` falls only after an acknowledge that leaves the word zero. An acknowledge that leaves bits set keeps the line high.
- R8: In message mode, each raise event that leaves the word nonzero gives a one-cycle `msg_pulse_o` in the next cycle. This holds even when the bits were already set, and back-to-back raises give back-to-back pulses. The level line is not changed by these raises.
- R9: In message mode, an acknowledge never deasserts `irq_level_o`.
- R10: A raise event that leaves the word zero (an empty mask on an empty word) produces neither a pulse nor a level change.
- R11: `status_o` shows the stored word. Holding the inputs idle for any number of cycles leaves the word and the interrupt outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| msg_mode_i | input | 1 | 1 selects message-pulse signalling, 0 selects the level line |
| sw_raise_i | input | 1 | Software raise strobe |
| sw_raise_mask_i | input | 32 | Bits to set on a software raise |
| sw_ack_i | input | 1 | Software acknowledge strobe |
| sw_ack_mask_i | input | 32 | Bits to clear on an acknowledge |
| compute_done_i | input | 1 | Compute-done event, sets bit 0 |
| xfer_done_i | input | 1 | Transfer-done event, sets bit 8 |
| status_o | output | 32 | Current status word |
| irq_level_o | output | 1 | Registered level interrupt line |
| msg_pulse_o | output | 1 | One-cycle message-interrupt pulse |

## Verification
The assertions assume that the mode input is changed only while the block is idle. They also assume that every strobe is valid for exactly the cycle in which it is sampled, so each input cycle maps to one update of the word. The bench follows these rules. It drives each input vector for a single cycle, starting at the falling edge, and changes `msg_mode_i` only on cycles with no raise and no acknowledge. Across the run it covers both modes, raises that repeat bits already set, empty masks, and cycles where an acknowledge and a raise collide.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int unsigned STATUS_W = 32;
  localparam int unsigned NUM_SRC  = 2;
  localparam int unsigned POS_W    = $clog2(STATUS_W);
  // Fixed bit position of each internal source; index 0 compute-done, 1 transfer-done.
  localparam logic [NUM_SRC-1:0][POS_W-1:0] SRC_POS = {POS_W'(8), POS_W'(0)};
  typedef logic [STATUS_W-1:0] word_t;
endpackage

// File: rtl/isc_set_merge.sv
module isc_set_merge
  import isc_pkg::*;
(
  input  logic               sw_raise_i,
  input  word_t              sw_raise_mask_i,
  input  logic [NUM_SRC-1:0] src_req_i,
  output word_t              set_mask_o,
  output logic               raise_ev_o
);
  word_t src_mask [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign src_mask[g] = src_req_i[g] ? (word_t'(1) << SRC_POS[g]) : '0;
  end

  always_comb begin
    set_mask_o = sw_raise_i ? sw_raise_mask_i : '0;
    for (int i = 0; i < NUM_SRC; i++) set_mask_o |= src_mask[i];
  end

  assign raise_ev_o = sw_raise_i | (|src_req_i);
endmodule

// File: rtl/isc_status_reg.sv
module isc_status_reg
  import isc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ack_i,
  input  word_t ack_mask_i,
  input  word_t set_mask_i,
  output word_t status_q_o,
  output logic  nxt_zero_o
);
  word_t status_q, status_d;

  // Clear before set so a coincident event survives.
  always_comb begin
    status_d = status_q;
    if (ack_i) status_d &= ~ack_mask_i;
    status_d |= set_mask_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= status_d;
  end

  assign status_q_o = status_q;
  assign nxt_zero_o = (status_d == '0);
endmodule

// File: rtl/isc_signal.sv
module isc_signal (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic msg_mode_i,
  input  logic raise_ev_i,
  input  logic ack_i,
  input  logic nxt_zero_i,
  output logic level_o,
  output logic pulse_o
);
  logic level_q, pulse_q, fire;

  assign fire = raise_ev_i & ~nxt_zero_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire & msg_mode_i;
      if (fire && !msg_mode_i)                    level_q <= 1'b1;
      else if (ack_i && nxt_zero_i && !msg_mode_i) level_q <= 1'b0;
    end
  end

  assign level_o = level_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import isc_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                msg_mode_i,
  input  logic                sw_raise_i,
  input  logic [STATUS_W-1:0] sw_raise_mask_i,
  input  logic                sw_ack_i,
  input  logic [STATUS_W-1:0] sw_ack_mask_i,
  input  logic                compute_done_i,
  input  logic                xfer_done_i,
  output logic [STATUS_W-1:0] status_o,
  output logic                irq_level_o,
  output logic                msg_pulse_o
);
  word_t              set_mask;
  logic               raise_ev, nxt_zero;
  logic [NUM_SRC-1:0] src_req;

  assign src_req = {xfer_done_i, compute_done_i};

  isc_set_merge i_merge (
    .sw_raise_i      (sw_raise_i),
    .sw_raise_mask_i (sw_raise_mask_i),
    .src_req_i       (src_req),
    .set_mask_o      (set_mask),
    .raise_ev_o      (raise_ev)
  );

  isc_status_reg i_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ack_i      (sw_ack_i),
    .ack_mask_i (sw_ack_mask_i),
    .set_mask_i (set_mask),
    .status_q_o (status_o),
    .nxt_zero_o (nxt_zero)
  );

  isc_signal i_sig (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .msg_mode_i (msg_mode_i),
    .raise_ev_i (raise_ev),
    .ack_i      (sw_ack_i),
    .nxt_zero_i (nxt_zero),
    .level_o    (irq_level_o),
    .pulse_o    (msg_pulse_o)
  );
endmodule

// File: rtl/isc_checker.sv
module isc_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        msg_mode_i,
  input logic        sw_raise_i,
  input logic [31:0] sw_raise_mask_i,
  input logic        sw_ack_i,
  input logic [31:0] sw_ack_mask_i,
  input logic        compute_done_i,
  input logic        xfer_done_i,
  input logic [31:0] status_o,
  input logic        irq_level_o,
  input logic        msg_pulse_o
);
  p_raise_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_raise_i |=> ((status_o & $past(sw_raise_mask_i)) == $past(sw_raise_mask_i)));

  p_ack_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_ack_i && !sw_raise_i && !compute_done_i && !xfer_done_i)
      |=> ((status_o & $past(sw_ack_mask_i)) == 32'd0));

  p_src_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (compute_done_i || xfer_done_i)
      |=> ((!$past(compute_done_i) || status_o[0]) && (!$past(xfer_done_i) || status_o[8])));

  p_level_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_level_o) |-> (status_o != 32'd0) && !$past(msg_mode_i));

  p_level_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_level_o) |-> (status_o == 32'd0));

  p_pulse_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_pulse_o |-> $past(msg_mode_i) && (status_o != 32'd0));

  p_msg_keeps_level_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_mode_i && irq_level_o) |=> irq_level_o);
endmodule

bind irq_status_unit isc_checker i_isc_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .msg_mode_i      (msg_mode_i),
  .sw_raise_i      (sw_raise_i),
  .sw_raise_mask_i (sw_raise_mask_i),
  .sw_ack_i        (sw_ack_i),
  .sw_ack_mask_i   (sw_ack_mask_i),
  .compute_done_i  (compute_done_i),
  .xfer_done_i     (xfer_done_i),
  .status_o        (status_o),
  .irq_level_o     (irq_level_o),
  .msg_pulse_o     (msg_pulse_o)
);

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        msg_mode_i = 1'b0;
  logic        sw_raise_i = 1'b0;
  logic [31:0] sw_raise_mask_i = '0;
  logic        sw_ack_i = 1'b0;
  logic [31:0] sw_ack_mask_i = '0;
  logic        compute_done_i = 1'b0;
  logic        xfer_done_i = 1'b0;
  logic [31:0] status_o;
  logic        irq_level_o;
  logic        msg_pulse_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] stat;
    logic        lvl;
    logic        pls;
    string       tag;
  } exp_t;

  exp_t q[$];
  logic [31:0] m_stat = '0;
  logic        m_lvl = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_status_unit i_irq_status_unit (
    .clk_i, .rst_ni, .msg_mode_i, .sw_raise_i, .sw_raise_mask_i, .sw_ack_i,
    .sw_ack_mask_i, .compute_done_i, .xfer_done_i, .status_o, .irq_level_o, .msg_pulse_o
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, expected result pushed for the monitor.
  task automatic drive(string tag, bit msg, bit rv, logic [31:0] rm, bit av, logic [31:0] am,
                       bit cd, bit xd);
    exp_t e;
    logic [31:0] nxt;
    bit sig;
    @(negedge clk_i);
    msg_mode_i = msg; sw_raise_i = rv; sw_raise_mask_i = rm;
    sw_ack_i = av; sw_ack_mask_i = am; compute_done_i = cd; xfer_done_i = xd;
    nxt = av ? (m_stat & ~am) : m_stat;
    nxt |= (rv ? rm : 32'd0) | (cd ? 32'h1 : 32'd0) | (xd ? 32'h100 : 32'd0);
    sig = (rv || cd || xd) && (nxt != 0);
    if (sig && !msg) m_lvl = 1'b1;
    else if (av && nxt == 0 && !msg) m_lvl = 1'b0;
    m_stat = nxt;
    e.stat = m_stat; e.lvl = m_lvl; e.pls = sig && msg; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(string tag, bit msg);
    drive(tag, msg, 0, 0, 0, 0, 0, 0);
  endtask

  // Monitor: compares just after each edge.
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, "status", status_o, e.stat);
        check(e.tag, "level", {31'd0, irq_level_o}, {31'd0, e.lvl});
        check(e.tag, "pulse", {31'd0, msg_pulse_o}, {31'd0, e.pls});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    // R1 reset state
    check("R1", "status", status_o, 32'd0);
    check("R1", "level", {31'd0, irq_level_o}, 32'd0);
    check("R1", "pulse", {31'd0, msg_pulse_o}, 32'd0);
    rst_ni = 1'b1;
    // R10 empty raise on empty word
    drive("R10", 0, 1, 32'd0, 0, 0, 0, 0);
    // R2 / R6 software raise, level mode
    drive("R2_R6", 0, 1, 32'hA000_0010, 0, 0, 0, 0);
    drive("R2", 0, 1, 32'h0000_0003, 0, 0, 0, 0);
    // R4 internal sources
    drive("R4", 0, 0, 0, 0, 0, 1, 0);
    drive("R4", 0, 0, 0, 0, 0, 0, 1);
    // R3 / R7 partial acknowledge keeps level
    drive("R3_R7", 0, 0, 0, 1, 32'h2000_0101, 0, 0);
    // R11 idle holds everything
    for (int i = 0; i < 4; i++) idle("R11", 0);
    // R5 collide: clear and set of bit 0 together, plus transfer event
    drive("R5", 0, 0, 0, 1, 32'h0000_0001, 1, 1);
    drive("R5", 0, 1, 32'h8000_0000, 1, 32'h8000_0000, 0, 0);
    // R7 clear all drops level
    drive("R7", 0, 0, 0, 1, 32'hFFFF_FFFF, 0, 0);
    idle("R7", 0);
    // Switch to message mode while idle
    drive("R6", 0, 1, 32'h0000_0040, 0, 0, 0, 0);
    idle("R9", 1);
    // R8 repeated raise of a set bit, back-to-back
    drive("R8", 1, 1, 32'h0000_0040, 0, 0, 0, 0);
    drive("R8", 1, 0, 0, 0, 0, 1, 0);
    drive("R8", 1, 0, 0, 0, 0, 1, 0);
    idle("R8", 1);
    // R9 full acknowledge in message mode keeps level
    drive("R9", 1, 0, 0, 1, 32'hFFFF_FFFF, 0, 0);
    idle("R9", 1);
    // R10 empty raise in message mode with empty word
    drive("R10", 1, 1, 32'd0, 0, 0, 0, 0);
    // R5 collision in message mode: ack clears all, raise survives
    drive("R5_R8", 1, 1, 32'h0000_0200, 1, 32'hFFFF_FFFF, 0, 0);
    idle("R11", 1);
    // Back to level mode, then clear
    idle("R7", 0);
    drive("R7", 0, 0, 0, 1, 32'h0000_0200, 0, 0);
    idle("R7", 0);
    @(negedge clk_i);
    @(negedge clk_i);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule